// File: doc/BRIEF.md
# Slice-Stepped Vector Transfer Sequencer

This block plays a short list of vector transfer operations for one vector code block, one slice at a time. Each entry is either a read, which takes the current slice of a named vector register and hands it to four 64-bit compute lanes together with an issue target, or a write, which returns the lanes' results to a named vector register as a slice-wide write request. The list is loaded while the block is idle. A start pulse then supplies the vector length in elements.

Entries issue strictly in list order. A read waits until the loader side reports that the current slice of its register is present. A write waits for the register side to accept it. When the last entry of the list has issued, the slice is finished. The same list then runs again for the next slice, until ceil(length/4) slices are covered. A one-cycle done pulse closes the block and empties the list. Vector work therefore chains slice by slice, without waiting for whole operands to arrive.

Top module: `vts_seq`

## Requirements
- R1: After reset, `busy`, `done`, `lane_valid` and `wr_valid` are all 0. While `busy` is 0, `lane_valid` is 0 and `wr_valid` is 0.
- R2: `q_push` appends one entry (kind `q_is_write`: 0 = read, 1 = write, plus register `q_vr` and target `q_tgt`) only while `busy` is 0 and fewer than QDEPTH entries are held. Otherwise the push is ignored. Entries issue in push order, and `rd_vr` shows the register of the current entry while busy.
- R3: A current read entry whose register has `slice_ready[vr]` at 0 stalls. `lane_valid` and `lane_data` are all zero, and the sequence does not move on.
- R4: A current read entry whose `slice_ready[vr]` is 1 issues in that cycle. `lane_valid` equals the slice lane mask, each valid lane i carries bits [64i+63:64i] of `rd_data` (invalid lanes carry zero), and `lane_tgt` equals the entry's target.
- R5: A current write entry drives `wr_valid` with `wr_vr`, `wr_mask` set to the slice lane mask, and `wr_data` set to `res_data`. The request is held unchanged until `wr_ready` is 1, and it issues in that cycle.
- R6: `cur_slice` starts at 0 and rises by exactly 1 only in the cycle after the last list entry issues on a slice that is not the final one.
- R7: When the last entry issues on slice ceil(length/4)-1, `done` is 1 for one cycle on the next cycle, and `busy` falls in that same cycle.
- R8: Lane i of a slice s is in the mask exactly when 4*s+i < length. Only the final slice can be partial, and its valid lanes are the low-numbered ones.
- R9: A start while busy is ignored. A start with length 0 or an empty list raises `done` on the next cycle and issues nothing.
- R10: Every completion empties the list, so a later start with no new pushes completes at once as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_push | input | 1 | Append an entry to the list |
| q_is_write | input | 1 | Entry kind: 0 read, 1 write |
| q_vr | input | 2 | Entry vector register |
| q_tgt | input | 2 | Issue target (reads only) |
| start | input | 1 | Begin the block |
| vlen | input | LEN_W | Vector length in elements, sampled at start |
| slice_ready | input | 4 | Per-register current-slice present flags |
| rd_vr | output | 2 | Register of the current entry |
| rd_data | input | 256 | Slice data of register `rd_vr` |
| lane_valid | output | 4 | Per-lane read issue |
| lane_data | output | 256 | Slice sent to the lanes, 64 bits per lane |
| lane_tgt | output | 2 | Issue target of the read |
| res_data | input | 256 | Lane results for a write |
| wr_valid | output | 1 | Slice write request |
| wr_vr | output | 2 | Register to write |
| wr_mask | output | 4 | Valid lanes of the write |
| wr_data | output | 256 | Write slice data |
| wr_ready | input | 1 | Register accepts the write |
| cur_slice | output | LEN_W | Slice index being processed |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hold property on write requests assumes that the register side does not expect the request to be withdrawn, and that `start` has no effect while busy. The bench therefore changes `res_data` freely but checks `wr_data` against the value applied in the same cycle. The properties also assume that `start` and `q_push` never fall in the same cycle, and that `start` is not raised in the cycle where `done` is high. The bench's stimulus tasks keep these apart. `slice_ready` and `wr_ready` are randomized every cycle so that stalls fall on every entry position and on partial slices.

// File: rtl/vts_pkg.sv
package vts_pkg;
    localparam int LANES   = 4;
    localparam int ELEM_W  = 64;
    localparam int SLICE_W = LANES * ELEM_W;
    localparam int NUM_VR  = 4;
    localparam int VR_W    = $clog2(NUM_VR);
    localparam int TGT_W   = 2;

    typedef enum logic {
        XFER_READ  = 1'b0,
        XFER_WRITE = 1'b1
    } xfer_kind_e;

    typedef struct packed {
        xfer_kind_e        kind;
        logic [VR_W-1:0]   vr;
        logic [TGT_W-1:0]  tgt;
    } xfer_entry_t;

    function automatic logic [31:0] slices_for(input logic [31:0] len);
        return (len + 32'(LANES) - 32'd1) / 32'(LANES);
    endfunction
endpackage

// File: rtl/vts_queue.sv
module vts_queue
    import vts_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  xfer_entry_t       push_entry,
    input  logic              clear,
    input  logic [PTR_W-1:0]  rd_idx,
    output xfer_entry_t       rd_entry,
    output logic [CNT_W-1:0]  count
);
    xfer_entry_t store_q [DEPTH];
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            for (int i = 0; i < DEPTH; i++) store_q[i] <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (push && (count_q < CNT_W'(DEPTH))) begin
            store_q[count_q[PTR_W-1:0]] <= push_entry;
            count_q <= count_q + CNT_W'(1);
        end
    end

    assign rd_entry = store_q[rd_idx];
    assign count    = count_q;
endmodule

// File: rtl/vts_lane_mask.sv
module vts_lane_mask
    import vts_pkg::*;
#(
    parameter int LEN_W = 12,
    localparam int AW = LEN_W + 3
) (
    input  logic [LEN_W-1:0] vlen,
    input  logic [LEN_W-1:0] slice,
    output logic [LANES-1:0] mask
);
    logic [AW-1:0] base;
    assign base = AW'(slice) * AW'(LANES);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mask[i] = (base + AW'(i)) < AW'(vlen);
    end
endmodule

// File: rtl/vts_seq.sv
module vts_seq
    import vts_pkg::*;
#(
    parameter int QDEPTH = 4,
    parameter int LEN_W  = 12,
    localparam int PTR_W = $clog2(QDEPTH),
    localparam int CNT_W = $clog2(QDEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               q_push,
    input  logic               q_is_write,
    input  logic [VR_W-1:0]    q_vr,
    input  logic [TGT_W-1:0]   q_tgt,
    input  logic               start,
    input  logic [LEN_W-1:0]   vlen,
    input  logic [NUM_VR-1:0]  slice_ready,
    output logic [VR_W-1:0]    rd_vr,
    input  logic [SLICE_W-1:0] rd_data,
    output logic [LANES-1:0]   lane_valid,
    output logic [SLICE_W-1:0] lane_data,
    output logic [TGT_W-1:0]   lane_tgt,
    input  logic [SLICE_W-1:0] res_data,
    output logic               wr_valid,
    output logic [VR_W-1:0]    wr_vr,
    output logic [LANES-1:0]   wr_mask,
    output logic [SLICE_W-1:0] wr_data,
    input  logic               wr_ready,
    output logic [LEN_W-1:0]   cur_slice,
    output logic               busy,
    output logic               done
);
    logic              busy_q, done_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [LEN_W-1:0]  slice_q, nslc_q, vlen_q;
    xfer_entry_t       cur, new_ent;
    logic [CNT_W-1:0]  qcount;
    logic [LANES-1:0]  mask;
    logic              is_rd, is_wr, rd_go, wr_go, step;
    logic              last_ent, last_slc, start_ok, empty_start, clear;

    assign new_ent.kind = q_is_write ? XFER_WRITE : XFER_READ;
    assign new_ent.vr   = q_vr;
    assign new_ent.tgt  = q_is_write ? '0 : q_tgt;

    vts_queue #(.DEPTH(QDEPTH)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .push       (q_push && !busy_q),
        .push_entry (new_ent),
        .clear      (clear),
        .rd_idx     (ptr_q),
        .rd_entry   (cur),
        .count      (qcount)
    );

    vts_lane_mask #(.LEN_W(LEN_W)) u_mask (
        .vlen  (vlen_q),
        .slice (slice_q),
        .mask  (mask)
    );

    assign is_rd    = busy_q && (cur.kind == XFER_READ);
    assign is_wr    = busy_q && (cur.kind == XFER_WRITE);
    assign rd_go    = is_rd && slice_ready[cur.vr];
    assign wr_go    = is_wr && wr_ready;
    assign step     = rd_go || wr_go;
    assign last_ent = CNT_W'(ptr_q) == (qcount - CNT_W'(1));
    assign last_slc = slice_q == (nslc_q - LEN_W'(1));
    assign start_ok = start && !busy_q;
    assign empty_start = start_ok && ((vlen == '0) || (qcount == '0));
    assign clear    = empty_start || (step && last_ent && last_slc);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            ptr_q   <= '0;
            slice_q <= '0;
            nslc_q  <= '0;
            vlen_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (empty_start) begin
                done_q <= 1'b1;
            end else if (start_ok) begin
                busy_q  <= 1'b1;
                ptr_q   <= '0;
                slice_q <= '0;
                vlen_q  <= vlen;
                nslc_q  <= LEN_W'(slices_for(32'(vlen)));
            end else if (step) begin
                if (last_ent) begin
                    ptr_q <= '0;
                    if (last_slc) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        slice_q <= slice_q + LEN_W'(1);
                    end
                end else begin
                    ptr_q <= ptr_q + PTR_W'(1);
                end
            end
        end
    end

    assign lane_valid = rd_go ? mask : '0;
    for (genvar i = 0; i < LANES; i++) begin : g_out
        assign lane_data[i*ELEM_W +: ELEM_W] =
            lane_valid[i] ? rd_data[i*ELEM_W +: ELEM_W] : '0;
    end
    assign lane_tgt  = rd_go ? cur.tgt : '0;
    assign rd_vr     = busy_q ? cur.vr : '0;
    assign wr_valid  = is_wr;
    assign wr_vr     = is_wr ? cur.vr : '0;
    assign wr_mask   = is_wr ? mask : '0;
    assign wr_data   = is_wr ? res_data : '0;
    assign cur_slice = slice_q;
    assign busy      = busy_q;
    assign done      = done_q;
endmodule

// File: rtl/vts_seq_chk.sv
module vts_seq_chk
    import vts_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic [LANES-1:0] lane_valid,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic [VR_W-1:0]  wr_vr,
    input logic [LEN_W-1:0] cur_slice
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (lane_valid == '0) && !wr_valid);

    a_r4_read_write_apart: assert property (@(posedge clk) disable iff (rst)
        (lane_valid != '0) |-> !wr_valid);

    a_r5_write_held: assert property (@(posedge clk) disable iff (rst)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_vr) && $stable(cur_slice));

    a_r6_slice_steps_by_one: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) && (cur_slice != $past(cur_slice))
            |-> cur_slice == $past(cur_slice) + LEN_W'(1));

    a_r7_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r8_low_lanes_first: assert property (@(posedge clk) disable iff (rst)
        $onehot0({1'b0, lane_valid} + (LANES+1)'(1)));
endmodule

bind vts_seq vts_seq_chk #(.LEN_W(LEN_W)) u_vts_seq_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .lane_valid (lane_valid),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_vr      (wr_vr),
    .cur_slice  (cur_slice)
);

// File: tb/vts_seq_test.sv
module vts_seq_test;
    localparam int LEN_W = 12;
    localparam int QD    = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic q_push = 0, q_is_write = 0, start = 0, wr_ready = 0;
    logic [1:0] q_vr = 0, q_tgt = 0;
    logic [LEN_W-1:0] vlen = 0;
    logic [3:0] slice_ready = 0;
    logic [255:0] rd_data = 0, res_data = 0;
    logic [1:0] rd_vr, lane_tgt, wr_vr;
    logic [3:0] lane_valid, wr_mask;
    logic [255:0] lane_data, wr_data;
    logic wr_valid, busy, done;
    logic [LEN_W-1:0] cur_slice;

    vts_seq #(.QDEPTH(QD), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst(rst), .q_push(q_push), .q_is_write(q_is_write),
        .q_vr(q_vr), .q_tgt(q_tgt), .start(start), .vlen(vlen),
        .slice_ready(slice_ready), .rd_vr(rd_vr), .rd_data(rd_data),
        .lane_valid(lane_valid), .lane_data(lane_data), .lane_tgt(lane_tgt),
        .res_data(res_data), .wr_valid(wr_valid), .wr_vr(wr_vr),
        .wr_mask(wr_mask), .wr_data(wr_data), .wr_ready(wr_ready),
        .cur_slice(cur_slice), .busy(busy), .done(done)
    );

    // behavioural reference
    int m_busy, m_done, m_ptr, m_slice, m_nslc, m_vlen, m_cnt;
    int m_kind[QD], m_vr[QD], m_tgt[QD];
    int vectors = 0, fails = 0, cycles = 0;
    bit cmp_en = 0;

    function automatic logic [3:0] ref_mask();
        logic [3:0] m;
        for (int i = 0; i < 4; i++) m[i] = (m_slice * 4 + i) < m_vlen;
        return m;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_busy = 0; m_done = 0; m_ptr = 0; m_slice = 0;
            m_nslc = 0; m_vlen = 0; m_cnt = 0;
        end else begin
            int step;
            step = 0;
            if (m_busy != 0) begin
                if (m_kind[m_ptr] == 0) step = slice_ready[m_vr[m_ptr]];
                else step = wr_ready;
            end
            m_done = 0;
            if (q_push && m_busy == 0 && m_cnt < QD) begin
                m_kind[m_cnt] = q_is_write; m_vr[m_cnt] = q_vr;
                m_tgt[m_cnt] = q_is_write ? 0 : q_tgt;
                m_cnt++;
            end
            if (start && m_busy == 0) begin
                if (vlen == 0 || m_cnt == 0) begin
                    m_done = 1; m_cnt = 0;
                end else begin
                    m_busy = 1; m_ptr = 0; m_slice = 0;
                    m_vlen = vlen; m_nslc = (vlen + 3) / 4;
                end
            end else if (step != 0) begin
                if (m_ptr == m_cnt - 1) begin
                    m_ptr = 0;
                    if (m_slice == m_nslc - 1) begin
                        m_busy = 0; m_done = 1; m_cnt = 0;
                    end else m_slice++;
                end else m_ptr++;
            end
        end
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en) begin
            logic [3:0] e_lv, e_wm, mk;
            logic [255:0] e_ld, e_wd;
            logic [1:0] e_tgt, e_wvr, e_rvr;
            bit rd, go, wr;
            vectors++;
            mk = ref_mask();
            rd = (m_busy != 0) && m_kind[m_ptr] == 0;
            wr = (m_busy != 0) && m_kind[m_ptr] == 1;
            go = rd && slice_ready[m_vr[m_ptr]];
            e_lv = go ? mk : 4'b0;
            e_ld = '0;
            for (int i = 0; i < 4; i++)
                if (e_lv[i]) e_ld[i*64 +: 64] = rd_data[i*64 +: 64];
            e_tgt = go ? 2'(m_tgt[m_ptr]) : 2'b0;
            e_rvr = (m_busy != 0) ? 2'(m_vr[m_ptr]) : 2'b0;
            e_wvr = wr ? 2'(m_vr[m_ptr]) : 2'b0;
            e_wm  = wr ? mk : 4'b0;
            e_wd  = wr ? res_data : '0;
            chk("R1 R7", "busy", 256'(busy), 256'(m_busy != 0));
            chk("R7 R9 R10", "done", 256'(done), 256'(m_done != 0));
            chk("R6", "cur_slice", 256'(cur_slice), 256'(m_slice));
            chk("R2", "rd_vr", 256'(rd_vr), 256'(e_rvr));
            chk("R3 R4 R8", "lane_valid", 256'(lane_valid), 256'(e_lv));
            chk("R3 R4", "lane_data", lane_data, e_ld);
            chk("R4", "lane_tgt", 256'(lane_tgt), 256'(e_tgt));
            chk("R5", "wr_valid", 256'(wr_valid), 256'(wr));
            chk("R5", "wr_vr", 256'(wr_vr), 256'(e_wvr));
            chk("R5 R8", "wr_mask", 256'(wr_mask), 256'(e_wm));
            chk("R5", "wr_data", wr_data, e_wd);
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic rnd_inputs(input int rdy_pct);
        slice_ready = 0;
        for (int v = 0; v < 4; v++) slice_ready[v] = ($urandom % 100) < rdy_pct;
        wr_ready = ($urandom % 100) < rdy_pct;
        for (int w = 0; w < 8; w++) begin
            rd_data[w*32 +: 32] = $urandom;
            res_data[w*32 +: 32] = $urandom;
        end
    endtask

    task automatic push(input bit w, input int vr, input int tgt);
        q_push = 1; q_is_write = w; q_vr = 2'(vr); q_tgt = 2'(tgt);
        tick();
        q_push = 0;
    endtask

    task automatic go(input int len);
        start = 1; vlen = LEN_W'(len);
        tick();
        start = 0;
    endtask

    task automatic run(input int rdy_pct);
        for (int n = 0; n < 4000 && m_busy != 0; n++) begin
            rnd_inputs(rdy_pct);
            if (n == 3) begin          // R2 R9: push and start while busy are ignored
                q_push = 1; q_is_write = 1; q_vr = 2'd3;
                start = 1; vlen = LEN_W'(40);
            end
            tick();
            q_push = 0; start = 0;
        end
        slice_ready = 0; wr_ready = 0;
        tick(); tick();
    endtask

    initial begin
        tick(); tick();
        cmp_en = 1;            // R1: reset state compared here
        tick();
        rst = 0;
        tick();
        // block A: 10 elements -> 3 slices, last mask 0011 (R8)
        push(0, 0, 1); push(0, 1, 2); push(1, 2, 0);
        go(10); run(60);
        // R3: explicit stall, slices never present for a while
        push(0, 3, 3); push(1, 0, 0);
        go(8);
        for (int k = 0; k < 6; k++) tick();
        run(40);
        // R9: length zero, then R10 list already emptied
        push(0, 1, 1);
        go(0); tick(); tick();
        go(5); tick(); tick();
        // R2: overfill, fifth push dropped; single element (R8)
        push(0, 0, 0); push(1, 1, 0); push(0, 2, 2); push(1, 3, 0); push(0, 1, 3);
        go(1); run(70);
        push(0, 2, 1); push(1, 1, 0); push(0, 3, 2); push(1, 0, 0);
        go(23); run(50);
        push(1, 3, 0);
        go(16); run(90);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule